// File: doc/BRIEF.md
# Configurable Interrupt Pin Driver

This block turns an internal interrupt event into the level on one physical interrupt pin. An 8-bit control register decides how the pin behaves. The pin can be switched off. Its active level can be high or low. It can hold the interrupt until software releases it, or it can emit a pulse. A pulse lasts a fixed time, one or two sample periods, or it follows the event in real time. The fixed time is 50 µs, or 10 µs when the sample rate is high. The pulse timer counts clock cycles, using the `CLK_HZ` parameter to convert the times, or it counts rising edges of the sample-rate tick.

Writes to the control register are accepted only while the device is not running (`op_run` low). Software releases a latched interrupt with a one-cycle release strobe. In every pulse mode other than real-time follow, the pin is expected to be paired with auto-clearing of the internal event status.

The control state machine has five states:
- `ST_OFF`: pin disabled. Entered from any state whenever the enable bit is 0. Leaves for `ST_IDLE` once the enable bit is 1.
- `ST_IDLE`: waiting for an event. It moves on as follows:
  - latched mode: a rising edge of the event goes to `ST_HOLD`;
  - pulsed mode with width code 00, 01 or 10: a rising edge of the event goes to `ST_PULSE` and starts the timer;
  - pulsed mode with width code 11: an event level of 1 goes to `ST_TRACK`.
- `ST_HOLD`: the pin is asserted. It returns to `ST_IDLE` on the release strobe.
- `ST_PULSE`: the pin is asserted. A new rising edge of the event restarts the timer and stays in `ST_PULSE`. When the timer expires, the state returns to `ST_IDLE`.
- `ST_TRACK`: the pin is asserted. It returns to `ST_IDLE` when the event level drops.

Top module: `intpin_driver`

## Requirements
- R1: After reset the control register reads 0x10: enabled off, active-high, latched mode, width code 00. The pin sits at its inactive level, 0.
- R2: A write with `cfg_we` high updates the register on that clock edge only while `op_run` is 0. A write while `op_run` is 1 leaves the register and the pin unchanged.
- R3: The register fields are as follows. All eight bits are stored and read back on `cfg_q`. Bits 2, 1 and 0 have no effect on the pin.

  | Bits | Field |
  |------|-------|
  | 7:6 | width code |
  | 5 | enable |
  | 4 | active level |
  | 3 | pulsed (1) / latched (0) |
  | 2 | reserved |
  | 1 | self-test polarity |
  | 0 | 3-wire serial enable |

- R4: With enable at 0 the pin is at its inactive level. Any latched state or running pulse is cleared on the next edge, so re-enabling shows no interrupt until a new event.
- R5: The pin is at its active level when asserted and at its inverse otherwise. The active level is bit 4: 1 means active-high, 0 means active-low.
- R6: In latched mode, a rising edge of the event asserts the pin from the next cycle. The pin stays asserted, also across further events, until the cycle after a release strobe.
- R7: With width code 00 the pin is asserted for CLK_HZ·50/10⁶ cycles. If the high-rate flag is 1 when the pulse starts, it is asserted for CLK_HZ·10/10⁶ cycles instead.
- R8: With width code 01 or 10, the pulse ends on the clock edge that sees the first or second rising edge of the sample tick after the pulse start.
- R9: With width code 11 in pulsed mode, the pin follows the event level with one cycle of delay.
- R10: A new rising edge of the event during a pulse restarts the full pulse length from that edge.
- R11: A held-high event does not start a new pulse or latch. Only a 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| op_run | input | 1 | Device running; blocks register writes when 1 |
| smp_tick | input | 1 | Sample-rate tick, counted on rising edges |
| hi_rate | input | 1 | Sample rate above 1600 Hz; shortens the fixed pulse |
| evt_in | input | 1 | Internal interrupt event level |
| rel_rd | input | 1 | Release-register read strobe |
| cfg_q | output | 8 | Current control register value |
| int_pin | output | 1 | Interrupt pin level |

## Verification
The assertions are checked on every cycle:
- A locked write leaves the register unchanged.
- A disabled pin is in `ST_OFF` one edge later.
- A latch survives until a release.
- A running pulse neither ends early nor lets its counter wrap.
- The follow state is only ever entered behind a high event.

Only the bench scenarios can show the things that need cycle counting against expected numbers:
- the exact pulse lengths for both fixed times;
- that a pulse ends on the first or second tick edge;
- that a retrigger restarts the full count;
- that each polarity gives the correct pin level.

// File: rtl/intpin_pkg.sv
package intpin_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_PULSE = 3'd3,
        ST_TRACK = 3'd4
    } pin_state_t;

    typedef struct packed {
        logic [1:0] width;
        logic       en;
        logic       act_hi;
        logic       pulsed;
        logic       resv;
        logic       st_pol;
        logic       wire3;
    } pin_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h10;

    localparam logic [1:0] W_FIXED  = 2'b00;
    localparam logic [1:0] W_ONE    = 2'b01;
    localparam logic [1:0] W_TWO    = 2'b10;
    localparam logic [1:0] W_FOLLOW = 2'b11;

endpackage

// File: rtl/intpin_cfg_reg.sv
module intpin_cfg_reg
    import intpin_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] RST_VAL = CFG_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          locked,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en && !locked) begin
            q <= wr_data;
        end
    end

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> $stable(q)) else $error("locked write changed register"); // R2

    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked) |=> (q == $past(wr_data))) else $error("open write not stored"); // R3

endmodule

// File: rtl/intpin_pulse_timer.sv
module intpin_pulse_timer
    import intpin_pkg::*;
#(
    parameter int LONG_CYC  = 6250,
    parameter int SHORT_CYC = 1250,
    localparam int CW       = (LONG_CYC < 3) ? 2 : $clog2(LONG_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic [1:0] width,
    input  logic       hi_rate,
    input  logic       smp_tick,
    output logic       expired
);

    localparam logic [CW-1:0] LOAD_LONG  = CW'(LONG_CYC);
    localparam logic [CW-1:0] LOAD_SHORT = CW'(SHORT_CYC);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          by_tick;
    logic          tick_d;
    logic          step;

    always_comb begin
        unique case (width)
            W_FIXED: load_val = hi_rate ? LOAD_SHORT : LOAD_LONG;
            W_ONE:   load_val = CW'(1);
            W_TWO:   load_val = CW'(2);
            default: load_val = '0;
        endcase
    end

    assign step    = by_tick ? (smp_tick & ~tick_d) : 1'b1;
    assign expired = step && (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            by_tick <= 1'b0;
            tick_d  <= 1'b0;
        end else begin
            tick_d <= smp_tick;
            if (clr) begin
                cnt <= '0;
            end else if (start) begin
                cnt     <= load_val;
                by_tick <= (width != W_FIXED);
            end else if (step && cnt != '0) begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !start) |=> (cnt == '0)) else $error("timer wrapped"); // R7

    AST_CNT_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (by_tick && !start && !clr && !(smp_tick && !tick_d)) |=> $stable(cnt)) else $error("tick count moved"); // R8

endmodule

// File: rtl/intpin_fsm.sv
module intpin_fsm
    import intpin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg,
    input  logic     evt_in,
    input  logic     rel_rd,
    input  logic     expired,
    output logic     active,
    output logic     tmr_start,
    output logic     tmr_clr
);

    pin_state_t state;
    pin_state_t nxt;
    logic       evt_d;
    logic       evt_rise;
    logic       timed_mode;

    assign evt_rise   = evt_in & ~evt_d;
    assign timed_mode = cfg.pulsed && (cfg.width != W_FOLLOW);

    always_comb begin
        nxt = state;
        if (!cfg.en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_IDLE;
                ST_IDLE: begin
                    if (!cfg.pulsed) begin
                        if (evt_rise) nxt = ST_HOLD;
                    end else if (cfg.width == W_FOLLOW) begin
                        if (evt_in) nxt = ST_TRACK;
                    end else if (evt_rise) begin
                        nxt = ST_PULSE;
                    end
                end
                ST_HOLD:  if (rel_rd) nxt = ST_IDLE;
                ST_PULSE: if (!evt_rise && expired) nxt = ST_IDLE;
                ST_TRACK: if (!evt_in) nxt = ST_IDLE;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            evt_d <= 1'b0;
        end else begin
            state <= nxt;
            evt_d <= evt_in;
        end
    end

    always_comb begin
        active    = (state == ST_HOLD) || (state == ST_PULSE) || (state == ST_TRACK);
        tmr_clr   = !cfg.en;
        tmr_start = cfg.en && timed_mode && evt_rise &&
                    ((state == ST_IDLE) || (state == ST_PULSE));
    end

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (state == ST_OFF)) else $error("not off when disabled"); // R4

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cfg.en && !rel_rd) |=> (state == ST_HOLD)) else $error("latch dropped"); // R6

    AST_PULSE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && cfg.en && !expired) |=> (state == ST_PULSE)) else $error("pulse ended early"); // R7

    AST_TRACK_BEHIND_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK) |-> $past(evt_in)) else $error("tracking without event"); // R9

    AST_NO_LEVEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg.en && !cfg.pulsed && evt_d) |=> (state != ST_HOLD)) else $error("held level latched"); // R11

endmodule

// File: rtl/intpin_driver.sv
module intpin_driver
    import intpin_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int LONG_US  = 50,
    parameter int SHORT_US = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       op_run,
    input  logic       smp_tick,
    input  logic       hi_rate,
    input  logic       evt_in,
    input  logic       rel_rd,
    output logic [7:0] cfg_q,
    output logic       int_pin
);

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int LONG_RAW   = CYC_PER_US * LONG_US;
    localparam int SHORT_RAW  = CYC_PER_US * SHORT_US;
    localparam int LONG_CYC   = (LONG_RAW < 1) ? 1 : LONG_RAW;
    localparam int SHORT_CYC  = (SHORT_RAW < 1) ? 1 : SHORT_RAW;

    pin_cfg_t cfg;
    logic     active;
    logic     tmr_start;
    logic     tmr_clr;
    logic     expired;

    intpin_cfg_reg #(
        .DW      (8),
        .RST_VAL (CFG_RESET)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .locked  (op_run),
        .q       (cfg_q)
    );

    assign cfg = pin_cfg_t'(cfg_q);

    intpin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .evt_in    (evt_in),
        .rel_rd    (rel_rd),
        .expired   (expired),
        .active    (active),
        .tmr_start (tmr_start),
        .tmr_clr   (tmr_clr)
    );

    intpin_pulse_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .start    (tmr_start),
        .width    (cfg.width),
        .hi_rate  (hi_rate),
        .smp_tick (smp_tick),
        .expired  (expired)
    );

    assign int_pin = active ? cfg.act_hi : ~cfg.act_hi;

    AST_DISABLED_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[5] |=> (int_pin == ~cfg_q[4])) else $error("disabled pin shows interrupt"); // R4

    AST_START_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> (int_pin == cfg_q[4])) else $error("pulse start not visible"); // R5

endmodule

// File: tb/sim_intpin_driver.sv
`timescale 1ns/1ps
module sim_intpin_driver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       op_run = 1'b0;
    logic       smp_tick = 1'b0;
    logic       hi_rate = 1'b0;
    logic       evt_in = 1'b0;
    logic       rel_rd = 1'b0;
    logic [7:0] cfg_q;
    logic       int_pin;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    localparam int LONG_N  = 50;
    localparam int SHORT_N = 10;

    always #4 clk = ~clk;

    intpin_driver #(.CLK_HZ(1_000_000), .LONG_US(50), .SHORT_US(10)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .op_run(op_run), .smp_tick(smp_tick), .hi_rate(hi_rate),
        .evt_in(evt_in), .rel_rd(rel_rd), .cfg_q(cfg_q), .int_pin(int_pin)
    );

    // {we, run, wdata[7:0], evt, rel, tick, expected pin}
    localparam int NV = 21;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 write enable, still off
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 idle
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 rise latches
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 held
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 second event, held
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 release
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},  // R11 level held, no relatch
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 active-low idle high
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 active-low asserted
        {1'b1, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 locked write ignored
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},  // R6 release
        {1'b1, 1'b0, 8'hE8, 1'b0, 1'b0, 1'b0, 1'b1},  // R9 follow mode, low active
        {1'b1, 1'b0, 8'hF8, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 follow, high active
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 follows
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R9
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R9 drops
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R9
        {1'b1, 1'b0, 8'h18, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 disable written
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 off
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0}   // R4 off
    };

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic run);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        op_run    = run;
        @(negedge clk);
        cfg_we = 1'b0;
        op_run = 1'b0;
    endtask

    task automatic measure(output int n);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        n = 0;
        while (int_pin == 1'b1 && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", cfg_q, 8'h10);
        chk("R1 reset pin", int_pin, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg after release", cfg_q, 8'h10);

        for (int i = 0; i < NV; i++) begin
            cfg_we    = VEC[i][13];
            op_run    = VEC[i][12];
            cfg_wdata = VEC[i][11:4];
            evt_in    = VEC[i][3];
            rel_rd    = VEC[i][2];
            smp_tick  = VEC[i][1];
            @(negedge clk);
            chk($sformatf("R4/R5/R6/R9/R11 vector %0d pin", i), int_pin, VEC[i][0]);
        end
        cfg_we = 1'b0; op_run = 1'b0; evt_in = 1'b0; rel_rd = 1'b0; smp_tick = 1'b0;
        @(negedge clk);

        // R2: locked write leaves register unchanged
        wr(8'hA5, 1'b1);
        chk("R2 locked write", cfg_q, 8'h18);

        // R3: all bits stored, low bits do not touch pin
        wr(8'h37, 1'b0);
        chk("R3 readback", cfg_q, 8'h37);
        @(negedge clk);
        @(negedge clk);
        chk("R3 low bits no pin effect", int_pin, 0);

        // R7: fixed pulse, normal and high rate
        wr(8'h38, 1'b0);
        repeat (2) @(negedge clk);
        measure(n);
        chk("R7 long pulse cycles", n, LONG_N);
        hi_rate = 1'b1;
        repeat (2) @(negedge clk);
        measure(n);
        chk("R7 short pulse cycles", n, SHORT_N);
        hi_rate = 1'b0;
        repeat (2) @(negedge clk);

        // R10: retrigger restarts the full length
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 mid pulse", int_pin, 1);
        measure(n);
        chk("R10 restarted length", n, LONG_N);

        // R8: one sample period
        wr(8'h78, 1'b0);
        repeat (2) @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 one-tick pulse before tick", int_pin, 1);
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        chk("R8 one-tick pulse ends", int_pin, 0);

        // R8: two sample periods
        wr(8'hB8, 1'b0);
        repeat (2) @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        chk("R8 two-tick pulse after first tick", int_pin, 1);
        repeat (3) @(negedge clk);
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        chk("R8 two-tick pulse ends", int_pin, 0);

        // R4: disabling clears a latch
        wr(8'h30, 1'b0);
        repeat (2) @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        chk("R4 latched before disable", int_pin, 1);
        wr(8'h10, 1'b0);
        @(negedge clk);
        chk("R4 disabled pin", int_pin, 0);
        wr(8'h30, 1'b0);
        repeat (2) @(negedge clk);
        chk("R4 latch cleared on re-enable", int_pin, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule